// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the input divider M, feedback multiplier N and post-divider index PL for a PLL. It is given a requested output rate and a reference clock, both as integer MHz values, together with a set of limits. It walks through the candidate combinations one at a time and keeps the one whose rounded output lies closest to twice the requested rate. It stops early as soon as it finds a candidate with zero error. All divisions share one iterative restoring divider, so each candidate takes a few dozen cycles and no wide combinational divide is built.

A start pulse copies every input into the engine and begins a search. When the search ends, a one-cycle done pulse presents the chosen coefficients together with two flags. One flag says the error reached zero. The other says no candidate passed the checks, in which case default coefficients are returned. Software or a sequencer then writes the result into the PLL. That programming step is not part of this block.

Top module: `pll_coef_search`

## Requirements
- R1: Each post-divider index maps to a fixed divide value. Indices 0 to 14 give 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32 in that order. `pl_o` reports the index, not the divide value.
- R2: The working target W is twice `tgt_mhz_i`. The bounding VCO is T = W + floor(W/50). The upper VCO limit used for the whole search is the larger of `vco_max_i` and T.
- R3: The high divide bound is ceil(VCOmax/T). The low divide bound is floor(`vco_min_i`/T). Each bound is first limited to at most `pdiv_max_i` and then raised to at least `pdiv_min_i`. Each then becomes the lowest index in 0..13 whose divide value is at least the bound, or 14 if no such index exists. The search covers the indices from low to high in increasing order.
- R4: For each index, M counts upward from `m_min_i` to `m_max_i`. If floor(ref/M) is below `cmp_min_i`, the engine moves to the next index. If it is above `cmp_max_i`, that M is skipped.
- R5: With V = W·div(PL), the N candidates run from floor(V·M/ref) to ceil(V·M/ref). If the lower value exceeds `n_max_i`, the engine moves to the next index. An N below `n_min_i` is skipped. An N above `n_max_i` ends the N run for that M.
- R6: A candidate is valid only if its VCO, floor(ref·N/M), lies between `vco_min_i` and the upper limit of R2, both inclusive. Its output is floor((VCO + floor(div/2))/div). Its error is the absolute difference between that output and W.
- R7: The kept candidate is replaced only by a candidate with a strictly smaller error. Among equal errors, the first one found is kept.
- R8: A zero-error candidate ends the search at once, and `exact_o` is high with the result.
- R9: If no candidate is valid, the result is M = `m_max_i`, N = `n_min_i` and PL = the low 4 bits of `pdiv_min_i`, with `nomatch_o` high and `exact_o` low.
- R10: `done_o` is high for exactly one cycle per search. `m_o`, `n_o`, `pl_o`, `exact_o` and `nomatch_o` change only in the cycle where `done_o` is high, and then hold.
- R11: A start pulse that arrives while a search is running is ignored. The running search finishes with the inputs it captured.
- R12: After reset, `done_o`, `m_o`, `n_o`, `pl_o`, `exact_o` and `nomatch_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search and captures all inputs |
| tgt_mhz_i | input | FW | Requested output rate, MHz |
| ref_mhz_i | input | FW | Reference clock, MHz (nonzero) |
| vco_min_i | input | FW | Lowest allowed VCO, MHz |
| vco_max_i | input | FW | Highest allowed VCO, MHz |
| cmp_min_i | input | FW | Lowest allowed ref/M, MHz |
| cmp_max_i | input | FW | Highest allowed ref/M, MHz |
| m_min_i | input | MW | Lowest M (nonzero) |
| m_max_i | input | MW | Highest M |
| n_min_i | input | NW | Lowest N |
| n_max_i | input | NW | Highest N |
| pdiv_min_i | input | DW | Lowest post-divide value |
| pdiv_max_i | input | DW | Highest post-divide value |
| m_o | output | MW | Chosen M |
| n_o | output | NW | Chosen N |
| pl_o | output | PLW | Chosen post-divider index |
| done_o | output | 1 | One-cycle pulse when a result is presented |
| exact_o | output | 1 | The chosen candidate has zero error |
| nomatch_o | output | 1 | No valid candidate was found; defaults returned |

## Verification
The bench uses the default parameters: FW=12, MW=8, NW=8, DW=6, PLW=4. These give 32-bit internal arithmetic and targets up to 4095 MHz. This range covers a request whose bounding VCO lies above the VCO limit, so the limit is raised. It also covers low targets whose divide bounds find no index in 0..13 and fall back to index 14. With 8-bit M, the default M limit of 255 is reachable. A reference of 100 MHz makes the engine skip M values whose ref/M is too high before it reaches usable ones. Narrowed limit sets drive the no-match default path with M, N and PL all moved away from their usual values.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int NUM_PL = 15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HI, ST_LO, ST_BOUND, ST_PL, ST_MCHK, ST_UDIV,
    ST_NDIV, ST_NCHK, ST_VDIV, ST_LDIV, ST_NEXT_PL, ST_FIN
  } pcs_state_e;

  // post-divide value for an index; deliberately non-monotonic above 9
  function automatic logic [5:0] pdiv_of(input logic [3:0] idx);
    case (idx)
      4'd0:  pdiv_of = 6'd1;
      4'd1:  pdiv_of = 6'd2;
      4'd2:  pdiv_of = 6'd3;
      4'd3:  pdiv_of = 6'd4;
      4'd4:  pdiv_of = 6'd5;
      4'd5:  pdiv_of = 6'd6;
      4'd6:  pdiv_of = 6'd8;
      4'd7:  pdiv_of = 6'd10;
      4'd8:  pdiv_of = 6'd12;
      4'd9:  pdiv_of = 6'd16;
      4'd10: pdiv_of = 6'd12;
      4'd11: pdiv_of = 6'd16;
      4'd12: pdiv_of = 6'd20;
      4'd13: pdiv_of = 6'd24;
      4'd14: pdiv_of = 6'd32;
      default: pdiv_of = 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W-1:0]  dvs_q;
  logic [W:0]    shf;

  assign shf = {rem_o, quo_o[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      dvs_q  <= '0;
      quo_o  <= '0;
      rem_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_o <= dvd_i;
        rem_o <= '0;
        dvs_q <= dvs_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (shf >= {1'b0, dvs_q}) begin
          rem_o <= W'(shf - {1'b0, dvs_q});
          quo_o <= {quo_o[W-2:0], 1'b1};
        end else begin
          rem_o <= shf[W-1:0];
          quo_o <= {quo_o[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcs_pdiv_index.sv
module pcs_pdiv_index
  import pcs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PLW = 4
) (
  input  logic [AW-1:0]  val_i,
  output logic [PLW-1:0] idx_o
);
  // lowest index below the last whose divide covers val_i, else the last
  always_comb begin
    idx_o = PLW'(NUM_PL - 1);
    for (int i = NUM_PL - 2; i >= 0; i--) begin
      if (AW'(pdiv_of(4'(i))) >= val_i) idx_o = PLW'(i);
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pcs_pkg::*;
#(
  parameter int FW  = 12,
  parameter int MW  = 8,
  parameter int NW  = 8,
  parameter int DW  = 6,
  parameter int PLW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [FW-1:0]  tgt_mhz_i,
  input  logic [FW-1:0]  ref_mhz_i,
  input  logic [FW-1:0]  vco_min_i,
  input  logic [FW-1:0]  vco_max_i,
  input  logic [FW-1:0]  cmp_min_i,
  input  logic [FW-1:0]  cmp_max_i,
  input  logic [MW-1:0]  m_min_i,
  input  logic [MW-1:0]  m_max_i,
  input  logic [NW-1:0]  n_min_i,
  input  logic [NW-1:0]  n_max_i,
  input  logic [DW-1:0]  pdiv_min_i,
  input  logic [DW-1:0]  pdiv_max_i,
  output logic [MW-1:0]  m_o,
  output logic [NW-1:0]  n_o,
  output logic [PLW-1:0] pl_o,
  output logic           done_o,
  output logic           exact_o,
  output logic           nomatch_o
);
  localparam int AW = 2 * FW + MW;
  localparam logic [AW-1:0] ERR_INIT = '1;

  pcs_state_e state;
  logic busy;

  logic [AW-1:0] wt, tv, vmin, vmax, umin, umax, mmin, mmax, nmin, nmax, pmin, pmax, refq;
  logic [AW-1:0] hi_val, lo_val, hi_c, lo_c, tvp, m_cur, n_cur, n_top;
  logic [AW-1:0] best_d, best_m, best_n;
  logic [PLW-1:0] pl_cur, pl_hi, best_pl, hi_idx, lo_idx;

  logic          div_go, div_done;
  logic [AW-1:0] div_a, div_b, quo, rem;

  logic [AW-1:0] wt_in, tv_in, vmax_in, err, pdv;

  assign busy    = (state != ST_IDLE);
  assign wt_in   = AW'(tgt_mhz_i) << 1;
  assign tv_in   = wt_in + wt_in / AW'(50);
  assign vmax_in = (AW'(vco_max_i) < tv_in) ? tv_in : AW'(vco_max_i);
  assign pdv     = AW'(pdiv_of(4'(pl_cur)));
  assign err     = (quo >= wt) ? quo - wt : wt - quo;

  always_comb begin
    hi_c = (hi_val > pmax) ? pmax : hi_val;
    if (hi_c < pmin) hi_c = pmin;
    lo_c = (lo_val > pmax) ? pmax : lo_val;
    if (lo_c < pmin) lo_c = pmin;
  end

  pcs_pdiv_index #(.AW(AW), .PLW(PLW)) u_hi_idx (.val_i(hi_c), .idx_o(hi_idx));
  pcs_pdiv_index #(.AW(AW), .PLW(PLW)) u_lo_idx (.val_i(lo_c), .idx_o(lo_idx));

  pcs_divider #(.W(AW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go),
    .dvd_i  (div_a),
    .dvs_i  (div_b),
    .done_o (div_done),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      {wt, tv, vmin, vmax, umin, umax, mmin, mmax} <= '0;
      {nmin, nmax, pmin, pmax, refq} <= '0;
      {hi_val, lo_val, tvp, m_cur, n_cur, n_top} <= '0;
      {best_d, best_m, best_n} <= '0;
      pl_cur  <= '0;
      pl_hi   <= '0;
      best_pl <= '0;
      div_go  <= 1'b0;
      div_a   <= '0;
      div_b   <= '0;
      m_o     <= '0;
      n_o     <= '0;
      pl_o    <= '0;
      done_o  <= 1'b0;
      exact_o <= 1'b0;
      nomatch_o <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          wt   <= wt_in;
          tv   <= tv_in;
          vmax <= vmax_in;
          vmin <= AW'(vco_min_i);
          umin <= AW'(cmp_min_i);
          umax <= AW'(cmp_max_i);
          mmin <= AW'(m_min_i);
          mmax <= AW'(m_max_i);
          nmin <= AW'(n_min_i);
          nmax <= AW'(n_max_i);
          pmin <= AW'(pdiv_min_i);
          pmax <= AW'(pdiv_max_i);
          refq <= AW'(ref_mhz_i);
          best_d  <= ERR_INIT;
          best_m  <= AW'(m_max_i);
          best_n  <= AW'(n_min_i);
          best_pl <= pdiv_min_i[PLW-1:0];
          div_a   <= vmax_in + tv_in - 1'b1;  // ceiling divide
          div_b   <= tv_in;
          div_go  <= 1'b1;
          state   <= ST_HI;
        end
        ST_HI: if (div_done) begin
          hi_val <= quo;
          div_a  <= vmin;
          div_b  <= tv;
          div_go <= 1'b1;
          state  <= ST_LO;
        end
        ST_LO: if (div_done) begin
          lo_val <= quo;
          state  <= ST_BOUND;
        end
        ST_BOUND: begin
          pl_cur <= lo_idx;
          pl_hi  <= hi_idx;
          state  <= (lo_idx > hi_idx) ? ST_FIN : ST_PL;
        end
        ST_PL: begin
          tvp   <= AW'(wt * pdv);
          m_cur <= mmin;
          state <= ST_MCHK;
        end
        ST_MCHK: begin
          if (m_cur > mmax) state <= ST_NEXT_PL;
          else begin
            div_a  <= refq;
            div_b  <= m_cur;
            div_go <= 1'b1;
            state  <= ST_UDIV;
          end
        end
        ST_UDIV: if (div_done) begin
          if (quo < umin) state <= ST_NEXT_PL;
          else if (quo > umax) begin
            m_cur <= m_cur + 1'b1;
            state <= ST_MCHK;
          end else begin
            div_a  <= AW'(tvp * m_cur);
            div_b  <= refq;
            div_go <= 1'b1;
            state  <= ST_NDIV;
          end
        end
        ST_NDIV: if (div_done) begin
          if (quo > nmax) state <= ST_NEXT_PL;
          else begin
            n_cur <= quo;
            n_top <= quo + AW'(rem != '0);
            state <= ST_NCHK;
          end
        end
        ST_NCHK: begin
          if (n_cur > n_top || n_cur > nmax) begin
            m_cur <= m_cur + 1'b1;
            state <= ST_MCHK;
          end else if (n_cur < nmin) begin
            n_cur <= n_cur + 1'b1;
          end else begin
            div_a  <= AW'(refq * n_cur);
            div_b  <= m_cur;
            div_go <= 1'b1;
            state  <= ST_VDIV;
          end
        end
        ST_VDIV: if (div_done) begin
          if (quo >= vmin && quo <= vmax) begin
            div_a  <= quo + (pdv >> 1);
            div_b  <= pdv;
            div_go <= 1'b1;
            state  <= ST_LDIV;
          end else begin
            n_cur <= n_cur + 1'b1;
            state <= ST_NCHK;
          end
        end
        ST_LDIV: if (div_done) begin
          if (err < best_d) begin
            best_d  <= err;
            best_m  <= m_cur;
            best_n  <= n_cur;
            best_pl <= pl_cur;
          end
          if (err == '0) state <= ST_FIN;
          else begin
            n_cur <= n_cur + 1'b1;
            state <= ST_NCHK;
          end
        end
        ST_NEXT_PL: begin
          if (pl_cur >= pl_hi) state <= ST_FIN;
          else begin
            pl_cur <= pl_cur + 1'b1;
            state  <= ST_PL;
          end
        end
        ST_FIN: begin
          m_o       <= best_m[MW-1:0];
          n_o       <= best_n[NW-1:0];
          pl_o      <= best_pl;
          exact_o   <= (best_d == '0);
          nomatch_o <= (best_d == ERR_INIT);
          done_o    <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int MW  = 8,
  parameter int NW  = 8,
  parameter int PLW = 4,
  parameter int AW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_i,
  input logic           done_o,
  input logic           exact_o,
  input logic           nomatch_o,
  input logic [MW-1:0]  m_o,
  input logic [NW-1:0]  n_o,
  input logic [PLW-1:0] pl_o,
  input logic [AW-1:0]  nmin_i,
  input logic [AW-1:0]  mmax_i
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({m_o, n_o, pl_o, exact_o, nomatch_o})); // R10
  AST_DONE_FROM_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_i)); // R11
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exact_o && nomatch_o)); // R9
  AST_NOMATCH_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && nomatch_o) |-> (AW'(n_o) == nmin_i && AW'(m_o) == mmax_i)); // R9
endmodule

bind pll_coef_search pcs_checker #(.MW(MW), .NW(NW), .PLW(PLW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy),
  .done_o   (done_o),
  .exact_o  (exact_o),
  .nomatch_o(nomatch_o),
  .m_o      (m_o),
  .n_o      (n_o),
  .pl_o     (pl_o),
  .nmin_i   (nmin),
  .mmax_i   (mmax)
);

// File: tb/sim_pll_coef_search.sv
`timescale 1ns/1ps
module sim_pll_coef_search;
  localparam int FW = 12, MW = 8, NW = 8, DW = 6, PLW = 4;

  typedef struct {
    int vmin, vmax, umin, umax, mmin, mmax, nmin, nmax, pmin, pmax;
  } lim_t;

  typedef struct packed {
    int m; int n; int pl; bit ex; bit nm;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] tgt = '0, rf = '0, vmin = '0, vmax = '0, umin = '0, umax = '0;
  logic [MW-1:0] mmin = '0, mmax = '0;
  logic [NW-1:0] nmin = '0, nmax = '0;
  logic [DW-1:0] pmin = '0, pmax = '0;
  logic [MW-1:0] m_o;
  logic [NW-1:0] n_o;
  logic [PLW-1:0] pl_o;
  logic done, exact, nomatch;

  int n_chk = 0, n_bad = 0;
  exp_t sb[$];
  string tagq[$];
  exp_t last;
  bit have_last = 0;
  bit prev_done = 0;

  always #10 clk = ~clk;

  pll_coef_search u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .tgt_mhz_i(tgt), .ref_mhz_i(rf), .vco_min_i(vmin), .vco_max_i(vmax),
    .cmp_min_i(umin), .cmp_max_i(umax), .m_min_i(mmin), .m_max_i(mmax),
    .n_min_i(nmin), .n_max_i(nmax), .pdiv_min_i(pmin), .pdiv_max_i(pmax),
    .m_o(m_o), .n_o(n_o), .pl_o(pl_o), .done_o(done), .exact_o(exact), .nomatch_o(nomatch)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input lim_t l, input int tg, input int r);
    int tbl[15];
    longint wt, tv, vmx, hi, lo, bd, tvp, u, nf, nc, vco, lw, d;
    int hix, lox, bm, bn, bp;
    bit hit;
    exp_t e;
    tbl = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    wt = 2 * tg; tv = wt + wt / 50;
    vmx = (l.vmax < tv) ? tv : l.vmax;
    hi = (vmx + tv - 1) / tv;
    if (hi > l.pmax) hi = l.pmax;
    if (hi < l.pmin) hi = l.pmin;
    lo = l.vmin / tv;
    if (lo > l.pmax) lo = l.pmax;
    if (lo < l.pmin) lo = l.pmin;
    hix = 14; lox = 14;
    for (int i = 13; i >= 0; i--) begin
      if (tbl[i] >= hi) hix = i;
      if (tbl[i] >= lo) lox = i;
    end
    bd = 64'hFFFF_FFFF; bm = l.mmax; bn = l.nmin; bp = l.pmin % 16; hit = 0;
    for (int p = lox; p <= hix && !hit; p++) begin
      tvp = wt * tbl[p];
      for (int m = l.mmin; m <= l.mmax && !hit; m++) begin
        u = r / m;
        if (u < l.umin) break;
        if (u > l.umax) continue;
        nf = tvp * m / r;
        nc = (tvp * m + r - 1) / r;
        if (nf > l.nmax) break;
        for (longint n = nf; n <= nc; n++) begin
          if (n < l.nmin) continue;
          if (n > l.nmax) break;
          vco = r * n / m;
          if (vco >= l.vmin && vco <= vmx) begin
            lw = (vco + tbl[p] / 2) / tbl[p];
            d = (lw > wt) ? lw - wt : wt - lw;
            if (d < bd) begin
              bd = d; bm = m; bn = int'(n); bp = p;
              if (d == 0) begin hit = 1; break; end
            end
          end
        end
      end
    end
    e.m = bm; e.n = bn; e.pl = bp; e.ex = (bd == 0); e.nm = (bd == 64'hFFFF_FFFF);
    return e;
  endfunction

  function automatic lim_t dflt();
    lim_t l;
    l.vmin = 1000; l.vmax = 2064; l.umin = 12; l.umax = 38;
    l.mmin = 1; l.mmax = 255; l.nmin = 8; l.nmax = 255; l.pmin = 1; l.pmax = 32;
    return l;
  endfunction

  task automatic drive(input lim_t l, input int tg, input int r);
    tgt = FW'(tg); rf = FW'(r);
    vmin = FW'(l.vmin); vmax = FW'(l.vmax); umin = FW'(l.umin); umax = FW'(l.umax);
    mmin = MW'(l.mmin); mmax = MW'(l.mmax); nmin = NW'(l.nmin); nmax = NW'(l.nmax);
    pmin = DW'(l.pmin); pmax = DW'(l.pmax);
  endtask

  // driver: pushes the expected result, then starts the search
  task automatic run_vec(input string tag, input lim_t l, input int tg, input int r,
                         input bit busy_poke);
    @(negedge clk);
    if (have_last) begin
      chk("R10", "held m_o", int'(m_o), last.m);
      chk("R10", "held n_o", int'(n_o), last.n);
    end
    sb.push_back(model(l, tg, r));
    tagq.push_back(tag);
    drive(l, tg, r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busy_poke) begin
      repeat (8) @(negedge clk);
      drive(dflt(), 500, 26);  // R11: new request while busy must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);  // an unexpected extra done would be reported by the monitor
  endtask

  // monitor: pops and compares on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk("R10", "done width", 2, 1);
      if (done) begin
        if (sb.size() == 0) chk("R11", "unexpected done", 1, 0);
        else begin
          exp_t e;
          string t;
          e = sb.pop_front();
          t = tagq.pop_front();
          chk(t, "m_o", int'(m_o), e.m);
          chk(t, "n_o", int'(n_o), e.n);
          chk(t, "pl_o", int'(pl_o), e.pl);
          chk(t, "exact_o", int'(exact), int'(e.ex));
          chk(t, "nomatch_o", int'(nomatch), int'(e.nm));
          last = e;
          have_last = 1;
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    lim_t l;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "done_o", int'(done), 0);
    chk("R12", "m_o", int'(m_o), 0);
    chk("R12", "n_o", int'(n_o), 0);
    chk("R12", "pl_o", int'(pl_o), 0);
    chk("R12", "flags", int'({exact, nomatch}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_vec("R8", dflt(), 72, 12, 0);   // exact hit at index 6 ends early
    run_vec("R4", dflt(), 396, 26, 0);
    run_vec("R6", dflt(), 852, 38, 0);
    run_vec("R4", dflt(), 612, 100, 0); // low M values skipped: ref/M above limit
    run_vec("R2", dflt(), 1100, 19, 0); // bounding VCO above limit raises it
    run_vec("R7", dflt(), 250, 27, 0);
    run_vec("R5", dflt(), 330, 31, 0);
    run_vec("R1", dflt(), 20, 12, 0);   // bounds fall back to index 14, divide 32
    run_vec("R9", dflt(), 300, 10, 0);  // ref below comparison floor: defaults
    l = dflt();
    l.vmin = 3000; l.vmax = 3100; l.mmax = 200; l.nmin = 20; l.pmin = 3;
    run_vec("R9", l, 100, 26, 0);       // no valid VCO: M=200, N=20, PL=3
    l = dflt();
    l.pmax = 4;
    run_vec("R3", l, 72, 12, 0);        // divide limit narrows index range to 3
    run_vec("R11", dflt(), 180, 26, 1);
    run_vec("R10", dflt(), 468, 38, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule